// File: doc/BRIEF.md
# Single-Address Accumulator Processor with Completion Handshake

This block is a small sequential processor that runs one instruction at a time. It moves through fetch, decode and execute steps over several clock cycles. Each instruction fills one 16-bit word. A 4-bit operation code sits in the top bits and a 12-bit direct address sits in the low bits. Three operations exist: load a word into the accumulator, add a word to the accumulator, and store the accumulator to memory. An unknown operation code parks the processor in a halted state.

Every memory access goes through an address register and a data buffer register. The processor raises either a read strobe or a write strobe, holds the address and write data steady, and waits for a completion input. Only then does it take the read data or end the write. This lets the block sit in front of memories with any response latency. The accumulator value is brought out so that a system can observe the running result.

Top module: `acc_cpu`

## Requirements
- R1: A word is 16 bits. Bits [15:12] hold the operation code and bits [11:0] hold the operand address. Each instruction occupies exactly one word.
- R2: Operation code 4'b0000 (load) reads the word at the operand address and places it in the accumulator.
- R3: Operation code 4'b1000 (add) reads the word at the operand address and adds it to the accumulator modulo 2^16. No carry is kept.
- R4: Operation code 4'b0001 (store) writes the accumulator value to the operand address.
- R5: The instruction at the address held in the program counter is fetched. The program counter then advances by exactly one, so instructions run in address order.
- R6: The program counter wraps from 12'hFFF to 12'h000.
- R7: At most one of the read and write strobes is high at any time. A raised strobe, its address and its write data stay unchanged until a cycle with completion high. Read data is taken only in that cycle. A write strobe stays high for one cycle more than the number of cycles completion is held off.
- R8: Any other operation code sets `halted`. The block then issues no further memory strobes and keeps the accumulator until reset.
- R9: Synchronous active-low reset clears the accumulator, the program counter and `halted`. It drops both strobes, and the first fetch after reset reads address 0.
- R10: Results do not depend on how many cycles the memory takes to signal completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_rd | output | 1 | Read strobe, held until completion |
| mem_wr | output | 1 | Write strobe, held until completion |
| mem_addr | output | 12 | Word address of the current access |
| mem_wdata | output | 16 | Write data, frozen during a write |
| mem_rdata | input | 16 | Read data, valid in the completion cycle |
| mem_done | input | 1 | Memory function complete |
| halted | output | 1 | High once an unknown operation code has been decoded |
| acc_value | output | 16 | Current accumulator contents |

## Verification
On every cycle, the assertions check the port handshake: only one strobe is raised at a time, and a strobe, its address and its write data stay stable while the memory has not completed. They also check that the halt is sticky and quiet, and that the program counter and accumulator change only when the controller asks for it. The bench scenarios cover the arithmetic results, including wrap-around of the sum, and the order of fetch addresses across the program counter wrap. They also cover read data being taken only in the completion cycle, which the bench tests by driving junk data on all other cycles. Finally, the scenarios show that results stay the same across different memory latencies.

// File: rtl/acc_cpu_pkg.sv
// Package: shared constants and types for the accumulator processor.
// Assumes a fixed 4-bit operation code at the top of each word.
package acc_cpu_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OP_LOAD  = 4'b0000;
    localparam logic [OPC_W-1:0] OP_ADD   = 4'b1000;
    localparam logic [OPC_W-1:0] OP_STORE = 4'b0001;

    // Sequencer steps of the multi-cycle machine
    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_FWAIT  = 3'd1,
        ST_DECODE = 3'd2,
        ST_EXEC   = 3'd3,
        ST_XRD    = 3'd4,
        ST_WB     = 3'd5,
        ST_XWR    = 3'd6,
        ST_HALT   = 3'd7
    } step_t;

    // Per-cycle enables produced by the sequencer
    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ir;
        logic mbr_from_mem;
        logic mbr_from_acc;
        logic ir_load;
        logic pc_inc;
        logic acc_load;
        logic acc_add;
        logic rd;
        logic wr;
        logic halt;
    } ctl_t;

endpackage

// File: rtl/acc_cpu_ctrl.sv
// Module: acc_cpu_ctrl
// Sequencer for fetch, decode and execute. It turns the current step, the
// decoded operation code and the memory completion into register enables.
// Assumes the memory needs at least one cycle per access.
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    input  logic             mem_done,
    output ctl_t             ctl
);

    step_t step_q, step_d;

    // Step register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= ST_FETCH;
        else        step_q <= step_d;
    end

    // Next step and enables for the current step
    always_comb begin
        step_d = step_q;
        ctl    = '0;
        unique case (step_q)
            ST_FETCH: begin
                ctl.mar_from_pc = 1'b1;
                step_d          = ST_FWAIT;
            end
            ST_FWAIT: begin
                ctl.rd = 1'b1;
                if (mem_done) begin
                    ctl.mbr_from_mem = 1'b1;
                    ctl.pc_inc       = 1'b1;
                    step_d           = ST_DECODE;
                end
            end
            ST_DECODE: begin
                ctl.ir_load = 1'b1;
                step_d      = ST_EXEC;
            end
            ST_EXEC: begin
                if (opcode == OP_LOAD || opcode == OP_ADD) begin
                    ctl.mar_from_ir = 1'b1;
                    step_d          = ST_XRD;
                end else if (opcode == OP_STORE) begin
                    ctl.mar_from_ir  = 1'b1;
                    ctl.mbr_from_acc = 1'b1;
                    step_d           = ST_XWR;
                end else begin
                    step_d = ST_HALT;
                end
            end
            ST_XRD: begin
                ctl.rd = 1'b1;
                if (mem_done) begin
                    ctl.mbr_from_mem = 1'b1;
                    step_d           = ST_WB;
                end
            end
            ST_WB: begin
                if (opcode == OP_ADD) ctl.acc_add  = 1'b1;
                else                  ctl.acc_load = 1'b1;
                step_d = ST_FETCH;
            end
            ST_XWR: begin
                ctl.wr = 1'b1;
                if (mem_done) step_d = ST_FETCH;
            end
            default: begin
                ctl.halt = 1'b1;
            end
        endcase
    end

    // R8: once halted, stay halted until reset
    p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.halt |=> ctl.halt);

    // R8: a halted machine raises no memory strobe
    p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.halt |-> !(ctl.rd || ctl.wr));

    // R7: a strobe stays up until the memory completes
    p_strobe_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.rd || ctl.wr) && !mem_done |=> (ctl.rd || ctl.wr));

endmodule

// File: rtl/acc_cpu_memif.sv
// Module: acc_cpu_memif
// Memory port holding the address register and data buffer register. It
// drives the strobes and keeps address and write data frozen until completion.
// Assumes the sequencer raises at most one strobe at a time.
module acc_cpu_memif #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mar_from_pc,
    input  logic              mar_from_ir,
    input  logic              mbr_from_mem,
    input  logic              mbr_from_acc,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] ir_addr,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_done,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] mbr
);

    logic [ADDR_W-1:0] mar_q;
    logic [DATA_W-1:0] mbr_q;

    // Address register: program counter on fetch, operand address on execute
    always_ff @(posedge clk) begin
        if (!rst_n)           mar_q <= '0;
        else if (mar_from_pc) mar_q <= pc;
        else if (mar_from_ir) mar_q <= ir_addr;
    end

    // Data buffer: read data in the completion cycle, or accumulator for a write
    always_ff @(posedge clk) begin
        if (!rst_n)            mbr_q <= '0;
        else if (mbr_from_mem) mbr_q <= mem_rdata;
        else if (mbr_from_acc) mbr_q <= acc;
    end

    // Port outputs come straight from the two registers
    always_comb begin
        mem_rd    = rd_req;
        mem_wr    = wr_req;
        mem_addr  = mar_q;
        mem_wdata = mbr_q;
        mbr       = mbr_q;
    end

    // R7: never read and write together
    p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R7: address and direction hold while waiting for completion
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) && !mem_done |=>
            $stable(mem_addr) && $stable(mem_rd) && $stable(mem_wr));

    // R7: write data frozen for the whole write
    p_wdata_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr && !mem_done |=> $stable(mem_wdata));

endmodule

// File: rtl/acc_cpu_regs.sv
// Module: acc_cpu_regs
// Program counter, instruction register and accumulator with its adder.
// Assumes each enable is raised for one cycle by the sequencer.
module acc_cpu_regs #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pc_inc,
    input  logic              ir_load,
    input  logic              acc_load,
    input  logic              acc_add,
    input  logic [DATA_W-1:0] mbr,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] ir,
    output logic [DATA_W-1:0] acc
);

    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] sum;

    // Program counter: step by one after each fetch, wrapping at the top
    always_ff @(posedge clk) begin
        if (!rst_n)      pc_q <= '0;
        else if (pc_inc) pc_q <= pc_q + ADDR_W'(1);
    end

    // Instruction register: copy of the fetched word from the buffer
    always_ff @(posedge clk) begin
        if (!rst_n)       ir_q <= '0;
        else if (ir_load) ir_q <= mbr;
    end

    // Modulo adder, no carry kept
    always_comb sum = acc_q + mbr;

    // Accumulator: load or add from the buffer register
    always_ff @(posedge clk) begin
        if (!rst_n)        acc_q <= '0;
        else if (acc_load) acc_q <= mbr;
        else if (acc_add)  acc_q <= sum;
    end

    // Register outputs
    always_comb begin
        pc  = pc_q;
        ir  = ir_q;
        acc = acc_q;
    end

    // R5: the program counter moves by exactly one per fetch
    p_pc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_inc |=> pc == $past(pc) + ADDR_W'(1));

    // R5: the program counter is quiet outside a fetch completion
    p_pc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_inc |=> $stable(pc));

    // R2: the accumulator changes only on a write-back
    p_acc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_load || acc_add) |=> $stable(acc));

    // R3: the accumulator never takes a load and an add in one cycle
    p_acc_one_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_load && acc_add));

endmodule

// File: rtl/acc_cpu.sv
// Module: acc_cpu (top)
// Single-address accumulator processor. It fetches one word per instruction,
// decodes the top operation code and executes load, add or store through a
// completion-gated memory port.
// Assumes DATA_W leaves exactly OPC_W bits above the address field.
module acc_cpu #(
    parameter int DATA_W = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    output logic                                  mem_rd,
    output logic                                  mem_wr,
    output logic [DATA_W-acc_cpu_pkg::OPC_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]                     mem_wdata,
    input  logic [DATA_W-1:0]                     mem_rdata,
    input  logic                                  mem_done,
    output logic                                  halted,
    output logic [DATA_W-1:0]                     acc_value
);
    import acc_cpu_pkg::*;

    localparam int ADDR_W = DATA_W - OPC_W;

    ctl_t              ctl;
    logic [ADDR_W-1:0] pc;
    logic [DATA_W-1:0] ir;
    logic [DATA_W-1:0] acc;
    logic [DATA_W-1:0] mbr;

    acc_cpu_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode   (ir[DATA_W-1 -: OPC_W]),
        .mem_done (mem_done),
        .ctl      (ctl)
    );

    acc_cpu_memif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_memif (
        .clk          (clk),
        .rst_n        (rst_n),
        .mar_from_pc  (ctl.mar_from_pc),
        .mar_from_ir  (ctl.mar_from_ir),
        .mbr_from_mem (ctl.mbr_from_mem),
        .mbr_from_acc (ctl.mbr_from_acc),
        .rd_req       (ctl.rd),
        .wr_req       (ctl.wr),
        .pc           (pc),
        .ir_addr      (ir[ADDR_W-1:0]),
        .acc          (acc),
        .mem_rdata    (mem_rdata),
        .mem_done     (mem_done),
        .mem_rd       (mem_rd),
        .mem_wr       (mem_wr),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mbr          (mbr)
    );

    acc_cpu_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .pc_inc   (ctl.pc_inc),
        .ir_load  (ctl.ir_load),
        .acc_load (ctl.acc_load),
        .acc_add  (ctl.acc_add),
        .mbr      (mbr),
        .pc       (pc),
        .ir       (ir),
        .acc      (acc)
    );

    // Observation outputs
    always_comb begin
        halted    = ctl.halt;
        acc_value = acc;
    end

endmodule

// File: tb/tb_acc_cpu.sv
// Bench for acc_cpu: a behavioural memory with adjustable completion delay,
// a vector table of load/add/store programs, then directed corner tests.
module tb_acc_cpu;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_rd, mem_wr, mem_done, halted;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata, acc_value;

    logic [15:0] mem [4096];
    int          delay = 0;
    int          cnt = 0;
    int          wr_cycles = 0;
    int          tests = 0;
    int          fails = 0;
    logic [11:0] rd_log [$];

    // {delay, word at FF0, word at FF1, expected sum}
    localparam logic [63:0] VEC [NVEC] = '{
        {16'd0, 16'h0005, 16'h0007, 16'h000C},
        {16'd3, 16'hFFFF, 16'h0001, 16'h0000},
        {16'd1, 16'h8000, 16'h8000, 16'h0000},
        {16'd5, 16'h1234, 16'h4321, 16'h5555},
        {16'd2, 16'h0000, 16'h0000, 16'h0000},
        {16'd7, 16'hFFF0, 16'h0020, 16'h0010}
    };

    acc_cpu dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_done  (mem_done),
        .halted    (halted),
        .acc_value (acc_value)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural memory: answers after 'delay' waiting cycles, junk data otherwise
    initial begin
        mem_done  = 1'b0;
        mem_rdata = 16'hDEAD;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                mem_done = 1'b0; cnt = 0; mem_rdata = 16'hDEAD;
            end else if (mem_done) begin
                mem_done = 1'b0; cnt = 0; mem_rdata = 16'hDEAD;
            end else if (mem_rd || mem_wr) begin
                if (mem_wr) wr_cycles++;
                if (cnt == delay) begin
                    mem_done = 1'b1;
                    if (mem_rd) begin
                        mem_rdata = mem[mem_addr];
                        rd_log.push_back(mem_addr);
                    end
                    if (mem_wr) mem[mem_addr] = mem_wdata;
                end else begin
                    cnt++;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic clear_mem(input logic [15:0] fill);
        for (int i = 0; i < 4096; i++) mem[i] = fill;
    endtask

    task automatic run_until_halt(input int max_cycles);
        for (int i = 0; i < max_cycles && !halted; i++) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (200000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R9: reset state
        clear_mem(16'hF000);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!mem_rd && !mem_wr, "R9 strobes low in reset", {mem_rd, mem_wr}, 0);
        check(acc_value == 16'h0, "R9 acc zero", acc_value, 0);
        check(!halted, "R9 not halted", halted, 0);
        rst_n = 1'b1;
        while (!mem_rd) @(negedge clk);
        check(mem_addr == 12'h000, "R9 first fetch address", mem_addr, 0);

        // R1 R2 R3 R4 R10: vector table of load/add/store programs
        for (int v = 0; v < NVEC; v++) begin
            clear_mem(16'h0000);
            mem[0] = 16'h0FF0;              // load FF0
            mem[1] = 16'h8FF1;              // add FF1
            mem[2] = 16'h1FF2;              // store FF2
            mem[3] = 16'h2000;              // unknown code, halts
            mem[12'hFF0] = VEC[v][47:32];
            mem[12'hFF1] = VEC[v][31:16];
            delay = int'(VEC[v][63:48]);
            do_reset();
            run_until_halt(2000);
            check(mem[12'hFF2] == VEC[v][15:0], "R4 R10 stored sum", mem[12'hFF2], VEC[v][15:0]);
            check(acc_value == VEC[v][15:0], "R3 acc sum modulo 2^16", acc_value, VEC[v][15:0]);
            check(halted, "R8 halt after program", halted, 1);
        end

        // R2 R7: plain load then store, read data taken only on completion
        clear_mem(16'h0000);
        mem[0] = 16'h0FF0; mem[1] = 16'h1FF3; mem[2] = 16'hF000;
        mem[12'hFF0] = 16'h0005;
        delay = 4;
        do_reset();
        wr_cycles = 0;
        run_until_halt(2000);
        check(acc_value == 16'h0005, "R2 load of 5", acc_value, 5);
        check(mem[12'hFF3] == 16'h0005, "R4 store of loaded value", mem[12'hFF3], 5);
        check(wr_cycles == 5, "R7 write strobe held until completion", wr_cycles, 5);

        // R8: halted machine stays quiet and keeps the accumulator
        clear_mem(16'h0000);
        mem[0] = 16'h0FF0; mem[1] = 16'h4000;
        mem[12'hFF0] = 16'h00AB;
        delay = 1;
        do_reset();
        run_until_halt(2000);
        begin
            int strobes = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (mem_rd || mem_wr) strobes++;
            end
            check(strobes == 0, "R8 no strobes after halt", strobes, 0);
        end
        check(halted, "R8 halt held", halted, 1);
        check(acc_value == 16'h00AB, "R8 acc kept after halt", acc_value, 16'h00AB);

        // R9: reset leaves the halted state and clears the accumulator
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check(!halted, "R9 reset clears halt", halted, 0);
        check(acc_value == 16'h0, "R9 reset clears acc", acc_value, 0);

        // R5 R6: program counter order and wrap (every word loads address 1)
        clear_mem(16'h0001);
        delay = 0;
        rd_log.delete();
        do_reset();
        for (int i = 0; i < 60000 && rd_log.size() < 8193; i++) @(negedge clk);
        check(rd_log.size() >= 8193, "R6 enough fetches", rd_log.size(), 8193);
        if (rd_log.size() >= 8193) begin
            check(rd_log[2] == 12'h001, "R5 second fetch address", rd_log[2], 1);
            check(rd_log[8190] == 12'hFFF, "R5 fetch at top address", rd_log[8190], 12'hFFF);
            check(rd_log[8191] == 12'h001, "R1 operand address field", rd_log[8191], 1);
            check(rd_log[8192] == 12'h000, "R6 wrap to zero", rd_log[8192], 0);
        end
        check(acc_value == 16'h0001, "R2 repeated load", acc_value, 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule